// File: doc/BRIEF.md
# PWM Timer with Buffered Compare Values

This block is a 16-bit up-counting timer that produces a pulse-width modulated output from two compare channels, A and B. The counter advances on each prescaled count-enable pulse while the timer is running. When the count equals compare B on such a tick, the counter restarts from zero, so one period lasts CB+1 ticks. The output pin is set by an A match and cleared by a B match. Each match also raises a sticky interrupt flag, and a per-channel enable gates that flag onto an interrupt line.

Each channel holds a live compare value and a shadow value. A mode bit in the control register chooses where bus accesses to the compare addresses go. With the bit clear, they go straight to the live values. With it set, they go to the shadow values, which are copied into the live values at the next counter restart. A restart comes from a B match or from a software reset. Software can therefore change duty and period in the middle of a period without producing a broken cycle.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After synchronous reset, all live and shadow compare values, the count, the control bits and both flags are 0, and the pin and both interrupt lines are low.
- R2: Register map, with read data registered one cycle after the address: 0 = compare A, 1 = compare B, 2 = control (bit0 run, bit1 buffered mode, bit2 software reset, bit3 A interrupt enable, bit4 B interrupt enable), 3 = flags (bit0 A, bit1 B), 4 = count (read-only).
- R3: With buffered mode clear, writes and reads at addresses 0 and 1 reach the live compare values directly.
- R4: With buffered mode set, writes and reads at addresses 0 and 1 reach the shadow values, and the live values stay unchanged until a counter restart.
- R5: A counter restart copies both shadow values into the live values only when buffered mode is set. The new values apply from count 0. A restart in direct mode leaves the live values unchanged.
- R6: On a tick the count increments by one, except that a tick at count == CB returns it to 0. The period is therefore CB+1 ticks.
- R7: A tick at count == CA sets the pin high and a tick at count == CB sets it low. B takes priority, so the pin is high for CB−CA of every CB+1 ticks.
- R8: A software reset, from either the sw_rst_i pulse or a write of 1 to control bit2, clears the count and drives the pin low on the next cycle. Control bit2 always reads 0.
- R9: A tick is run AND cnt_en_i. Without a tick the count holds its value.
- R10: Match flags are sticky. Writing 1 to a flag bit clears it. Each interrupt line is its flag ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Registered read data |
| cnt_en_i | input | 1 | Prescaled count-enable pulse |
| sw_rst_i | input | 1 | Software counter reset pulse |
| irq_a_o | output | 1 | Compare A interrupt |
| irq_b_o | output | 1 | Compare B interrupt |
| pwm_o | output | 1 | PWM output pin |

## Verification
The bench measures period and high time of the pin in four settings. It runs direct mode (CA=3, CB=9), buffered mode reloaded by a B match (CA=2, CB=7), a half-rate count enable (which doubles both figures), and CA equal to CB (which must keep the pin low). Comparing shadow and live read-backs before and after a software restart separates the buffered path from the direct path. A read-back after running in direct mode shows that a B match does not copy the zero shadows. Flag tests with one enable set tell the sticky flag apart from its gated interrupt line.

// File: rtl/pwm_cmp_pkg.sv
`timescale 1ns/1ps
package pwm_cmp_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;

  // control bit positions
  localparam int CB_RUN = 0;
  localparam int CB_BUF = 1;
  localparam int CB_SWR = 2;
  localparam int CB_IE0 = 3;   // enables occupy CB_IE0 + channel

  typedef enum logic [ADDR_W-1:0] {
    REG_CMP_A = 3'd0,
    REG_CMP_B = 3'd1,
    REG_CTRL  = 3'd2,
    REG_FLAGS = 3'd3,
    REG_COUNT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/pwm_cmp_regs.sv
`timescale 1ns/1ps
module pwm_cmp_regs
  import pwm_cmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [W-1:0]                 wdata,
  input  logic                         we,
  input  logic [W-1:0]                 cnt_q,
  input  logic [NUM_CH-1:0]            evt,
  input  logic                         restart,
  output logic [NUM_CH-1:0][W-1:0]     live_q,
  output logic                         run_q,
  output logic [NUM_CH-1:0]            irq,
  output logic [W-1:0]                 rdata
);
  logic                        buf_en_q;
  logic [NUM_CH-1:0]           ie_q;
  logic [NUM_CH-1:0]           flag_q;
  logic [NUM_CH-1:0][W-1:0]    shadow_q;
  logic                        wr_ctrl, wr_flags;

  assign wr_ctrl  = we && (addr == REG_CTRL);
  assign wr_flags = we && (addr == REG_FLAGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      buf_en_q <= 1'b0;
      ie_q     <= '0;
    end else if (wr_ctrl) begin
      run_q    <= wdata[CB_RUN];
      buf_en_q <= wdata[CB_BUF];
      ie_q     <= wdata[CB_IE0 +: NUM_CH];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic wr_cmp;
    assign wr_cmp = we && (addr == ADDR_W'(ch));

    always_ff @(posedge clk) begin
      if (rst) begin
        live_q[ch]   <= '0;
        shadow_q[ch] <= '0;
      end else begin
        if (wr_cmp && buf_en_q)
          shadow_q[ch] <= wdata;
        if (wr_cmp && !buf_en_q)
          live_q[ch] <= wdata;
        else if (restart && buf_en_q)
          live_q[ch] <= shadow_q[ch];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)
        flag_q[ch] <= 1'b0;
      else if (evt[ch])
        flag_q[ch] <= 1'b1;
      else if (wr_flags && wdata[ch])
        flag_q[ch] <= 1'b0;
    end

    assign irq[ch] = flag_q[ch] & ie_q[ch];
  end

  logic [W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (addr)
      REG_CMP_A: rd_next = buf_en_q ? shadow_q[CH_A] : live_q[CH_A];
      REG_CMP_B: rd_next = buf_en_q ? shadow_q[CH_B] : live_q[CH_B];
      REG_CTRL: begin
        rd_next[CB_RUN]            = run_q;
        rd_next[CB_BUF]            = buf_en_q;
        rd_next[CB_IE0 +: NUM_CH]  = ie_q;
      end
      REG_FLAGS: rd_next[NUM_CH-1:0] = flag_q;
      REG_COUNT: rd_next = cnt_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/pwm_cmp_counter.sv
`timescale 1ns/1ps
module pwm_cmp_counter
  import pwm_cmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic                     swr,
  input  logic [NUM_CH-1:0][W-1:0] live,
  output logic [W-1:0]             cnt_q,
  output logic [NUM_CH-1:0]        evt,
  output logic                     wrap
);
  logic [NUM_CH-1:0] match;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    assign match[ch] = (cnt_q == live[ch]);
    assign evt[ch]   = match[ch] & tick;
  end

  assign wrap = evt[CH_B];

  always_ff @(posedge clk) begin
    if (rst || swr)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= match[CH_B] ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/pwm_cmp_pin.sv
`timescale 1ns/1ps
module pwm_cmp_pin
  import pwm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              swr,
  input  logic [NUM_CH-1:0] evt,
  output logic              pin_q
);
  always_ff @(posedge clk) begin
    if (rst || swr)       pin_q <= 1'b0;
    else if (evt[CH_B])   pin_q <= 1'b0;
    else if (evt[CH_A])   pin_q <= 1'b1;
  end
endmodule

// File: rtl/pwm_cmp_timer.sv
`timescale 1ns/1ps
module pwm_cmp_timer
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cnt_en_i,
  input  logic              sw_rst_i,
  output logic              irq_a_o,
  output logic              irq_b_o,
  output logic              pwm_o
);
  logic [NUM_CH-1:0][CNT_W-1:0] live_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [NUM_CH-1:0]            evt, irq;
  logic                         run_q, tick, swr, wrap;

  assign tick = run_q & cnt_en_i;
  assign swr  = sw_rst_i | (bus_we && (bus_addr == REG_CTRL) && bus_wdata[CB_SWR]);

  pwm_cmp_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .cnt_q(cnt_q), .evt(evt), .restart(swr | wrap),
    .live_q(live_q), .run_q(run_q), .irq(irq), .rdata(bus_rdata)
  );

  pwm_cmp_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .swr(swr), .live(live_q),
    .cnt_q(cnt_q), .evt(evt), .wrap(wrap)
  );

  pwm_cmp_pin u_pin (
    .clk(clk), .rst(rst), .swr(swr), .evt(evt), .pin_q(pwm_o)
  );

  assign irq_a_o = irq[CH_A];
  assign irq_b_o = irq[CH_B];
endmodule

// File: rtl/pwm_cmp_timer_chk.sv
`timescale 1ns/1ps
module pwm_cmp_timer_chk
  import pwm_cmp_pkg::*;
#(
  parameter int W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick,
  input logic                     swr,
  input logic [W-1:0]             cnt,
  input logic [NUM_CH-1:0][W-1:0] live,
  input logic                     pwm
);
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !swr && cnt != live[CH_B]) |=> cnt == $past(cnt) + W'(1));

  assert_cnt_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !swr && cnt == live[CH_B]) |=> cnt == '0);

  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !swr) |=> $stable(cnt));

  assert_swr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    swr |=> (cnt == '0 && !pwm));

  assert_pin_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !swr && cnt == live[CH_A] && cnt != live[CH_B]) |=> pwm);

  assert_pin_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == live[CH_B]) |=> !pwm);
endmodule

bind pwm_cmp_timer pwm_cmp_timer_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .swr(swr),
  .cnt(cnt_q), .live(live_q), .pwm(pwm_o)
);

// File: tb/pwm_cmp_timer_bench.sv
`timescale 1ns/1ps
module pwm_cmp_timer_bench;
  localparam int W = 16;
  localparam logic [2:0] A_CMPA = 3'd0, A_CMPB = 3'd1, A_CTRL = 3'd2,
                         A_FLAGS = 3'd3, A_COUNT = 3'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic bus_we = 1'b0, cnt_en_i = 1'b1, sw_rst_i = 1'b0;
  logic [W-1:0] bus_rdata;
  logic irq_a_o, irq_b_o, pwm_o;
  logic half_rate = 1'b0;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_cmp_timer #(.CNT_W(W)) u_pwm_cmp_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .cnt_en_i(cnt_en_i),
    .sw_rst_i(sw_rst_i), .irq_a_o(irq_a_o), .irq_b_o(irq_b_o), .pwm_o(pwm_o)
  );

  always @(negedge clk) cnt_en_i <= half_rate ? ~cnt_en_i : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic measure(output int period, output int high);
    logic prev;
    prev = pwm_o; period = 0; high = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!prev && pwm_o) break;
      prev = pwm_o;
    end
    prev = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      period++;
      if (pwm_o) high++;
      if (!prev && pwm_o) break;
      prev = pwm_o;
    end
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    chk("R1 pin low", pwm_o, 0);
    chk("R1 irq low", {irq_a_o, irq_b_o}, 0);
    rd(A_CMPA, d);  chk("R1 R2 cmpA zero", d, 0);
    rd(A_CMPB, d);  chk("R1 R2 cmpB zero", d, 0);
    rd(A_CTRL, d);  chk("R1 R2 ctrl zero", d, 0);
    rd(A_FLAGS, d); chk("R1 R2 flags zero", d, 0);
    rd(A_COUNT, d); chk("R1 R2 count zero", d, 0);
    wr(A_CTRL, 16'h0002);
    rd(A_CMPA, d);  chk("R1 shadow A zero", d, 0);
    rd(A_CMPB, d);  chk("R1 shadow B zero", d, 0);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_direct;
    logic [W-1:0] d; int p, h;
    wr(A_CMPA, 3); wr(A_CMPB, 9);
    rd(A_CMPA, d); chk("R3 direct A readback", d, 3);
    rd(A_CMPB, d); chk("R3 direct B readback", d, 9);
    wr(A_CTRL, 16'h0001);
    measure(p, h); measure(p, h);
    chk("R6 period CB+1", p, 10);
    chk("R7 high time CB-CA", h, 6);
    rd(A_CMPA, d); chk("R5 direct mode no copy A", d, 3);
    rd(A_CMPB, d); chk("R5 direct mode no copy B", d, 9);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_buffered_sw;
    logic [W-1:0] d;
    wr(A_CTRL, 16'h0002);
    wr(A_CMPA, 1); wr(A_CMPB, 4);
    rd(A_CMPA, d); chk("R4 shadow A readback", d, 1);
    rd(A_CMPB, d); chk("R4 shadow B readback", d, 4);
    wr(A_CTRL, 16'h0000);
    rd(A_CMPA, d); chk("R4 live A untouched", d, 3);
    rd(A_CMPB, d); chk("R4 live B untouched", d, 9);
    wr(A_CTRL, 16'h0002);
    @(negedge clk); sw_rst_i = 1'b1;
    @(negedge clk); sw_rst_i = 1'b0;
    chk("R8 pin low after sw_rst_i", pwm_o, 0);
    wr(A_CTRL, 16'h0000);
    rd(A_CMPA, d); chk("R5 sw reset copied A", d, 1);
    rd(A_CMPB, d); chk("R5 sw reset copied B", d, 4);
    rd(A_COUNT, d); chk("R8 count zero after sw_rst_i", d, 0);
  endtask

  task automatic t_buffered_bmatch;
    int p, h;
    wr(A_CTRL, 16'h0002);
    wr(A_CMPA, 2); wr(A_CMPB, 7);
    wr(A_CTRL, 16'h0003);
    measure(p, h); measure(p, h);
    chk("R5 R6 period after B-match reload", p, 8);
    chk("R5 R7 high after B-match reload", h, 5);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_prescale;
    logic [W-1:0] a, b; int p, h;
    half_rate = 1'b1;
    wr(A_CTRL, 16'h0001);
    measure(p, h); measure(p, h);
    chk("R9 half-rate period", p, 16);
    chk("R9 half-rate high", h, 10);
    wr(A_CTRL, 16'h0000);
    half_rate = 1'b0;
    rd(A_COUNT, a);
    repeat (5) @(negedge clk);
    rd(A_COUNT, b);
    chk("R9 count holds when stopped", b, a);
  endtask

  task automatic t_swreset_bit;
    logic [W-1:0] d;
    wr(A_CTRL, 16'h0004);
    wr(A_CMPA, 5); wr(A_CMPB, 16'hFFFF);
    wr(A_CTRL, 16'h0001);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 16'h0000);
    chk("R7 pin high past CA", pwm_o, 1);
    rd(A_COUNT, d); chk("R6 count advanced", (d > 5), 1);
    wr(A_CTRL, 16'h0004);
    chk("R8 ctrl bit2 drives pin low", pwm_o, 0);
    rd(A_COUNT, d); chk("R8 ctrl bit2 clears count", d, 0);
    rd(A_CTRL, d);  chk("R8 ctrl bit2 reads zero", d, 0);
  endtask

  task automatic t_equal;
    int highs;
    wr(A_CMPA, 4); wr(A_CMPB, 4);
    wr(A_CTRL, 16'h0001);
    highs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
    chk("R7 B wins when CA==CB", highs, 0);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_flags;
    logic [W-1:0] d;
    wr(A_CTRL, 16'h0008);
    wr(A_FLAGS, 16'h0003);
    rd(A_FLAGS, d); chk("R10 flags cleared", d, 0);
    chk("R10 irq A low after clear", irq_a_o, 0);
    wr(A_CTRL, 16'h0009);
    repeat (30) @(negedge clk);
    wr(A_CTRL, 16'h0008);
    rd(A_FLAGS, d); chk("R10 both flags sticky", d, 3);
    chk("R10 irq A enabled", irq_a_o, 1);
    chk("R10 irq B gated off", irq_b_o, 0);
    wr(A_FLAGS, 16'h0001);
    rd(A_FLAGS, d); chk("R10 W1C clears only A", d, 2);
    chk("R10 irq A low after W1C", irq_a_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direct();
    t_buffered_sw();
    t_buffered_bmatch();
    t_prescale();
    t_swreset_bit();
    t_equal();
    t_flags();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule